// File: doc/BRIEF.md
# Radix-4 Booth Sequential Signed Multiplier

This block multiplies two 32-bit two's-complement operands and returns the 64-bit signed product as a high word and a low word. It works through the multiplier two bits at a time. Each step reads the two lowest bits of the low word together with the bit that was shifted out on the previous step. From these three bits it decides whether to add or subtract nothing, once the multiplicand, or twice the multiplicand. The high half of the running product is held two bits wider than the operands. This stops the partial sum from overflowing, and it lets every shift copy the correct sign into the vacated top bits.

A caller presents both operands with a one-cycle `start` pulse while the block is idle. `busy` is then high for sixteen cycles. `done` pulses for one cycle when the product is ready, and the result words stay unchanged until the next accepted start. A start pulse that arrives while a multiply is in progress is dropped.

Top module: `booth_radix4_mul`

## Requirements
- R1: When `done` is high, `{hi, lo}` equals the signed 64-bit product of the multiplicand and multiplier captured at the accepted start. This includes the most negative operand values.
- R2: A `start` seen high at a rising edge while `busy` is low is accepted. After that edge, `busy` is 1, `hi` is 0 and `lo` holds the multiplier.
- R3: A multiply takes 16 steps. `busy` stays high for exactly 16 cycles after the accepting edge, and `done` goes high at the same edge where `busy` falls.
- R4: `done` is high for exactly one cycle per multiply, and it is never high together with `busy`.
- R5: `start` and operand changes while `busy` is high have no effect. The result and the timing of `done` are those of the operation already in progress.
- R6: While idle with no `start`, `hi` and `lo` hold their values.
- R7: Each step recodes the three bits {lo[1], lo[0], previous lo[1]} as follows: 000 and 111 make no change; 001 and 010 add 1x; 011 adds 2x; 100 subtracts 2x; 101 and 110 subtract 1x. The previous bit is 0 at start.
- R8: After reset, `busy`, `done`, `hi` and `lo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; acted on only when idle |
| mcand | input | 32 | Signed multiplicand |
| mplier | input | 32 | Signed multiplier |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse: the product is valid |
| hi | output | 32 | Upper half of the product |
| lo | output | 32 | Lower half of the product |

## Verification
The assertions assume that `start` is a clean synchronous level. They also assume that a value sampled at the accepting edge is the one the caller intends to multiply, so `mplier` is compared with its value one cycle earlier. The bench drives every input at the falling edge, holds `start` for a single cycle for each request, and sends extra start pulses and new operands in the middle of a run. This shows that those inputs are not sampled. The random operands are mixed with directed values at both signed extremes and with alternating bit patterns, so that every row of the recoding table is reached.

// File: rtl/booth_radix4_mul.sv
module booth_radix4_mul #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  localparam int AW    = WIDTH + 2;
  localparam int STEPS = WIDTH / 2;
  localparam int CW    = $clog2(STEPS + 1);

  logic [AW-1:0]    acc_q;
  logic [WIDTH-1:0] lo_q;
  logic [WIDTH-1:0] mcand_q;
  logic             prev_q;
  logic             busy_q;
  logic             done_q;
  logic [CW-1:0]    step_q;

  logic op_en, op_two, op_sub;
  logic [AW-1:0] one_x, two_x, multiple, addend, psum;

  wire hi_clr    = start && !busy_q;
  wire lo_ld     = hi_clr;
  wire shift_all = busy_q;
  wire hi_ld     = shift_all;
  wire last_step = (step_q == CW'(STEPS - 1));

  always_comb begin
    op_en  = 1'b0;
    op_two = 1'b0;
    op_sub = 1'b0;
    unique case ({lo_q[1:0], prev_q})
      3'b001, 3'b010: op_en = 1'b1;
      3'b011:         begin op_en = 1'b1; op_two = 1'b1; end
      3'b100:         begin op_en = 1'b1; op_two = 1'b1; op_sub = 1'b1; end
      3'b101, 3'b110: begin op_en = 1'b1; op_sub = 1'b1; end
      default: ;
    endcase
  end

  assign one_x    = {{2{mcand_q[WIDTH-1]}}, mcand_q};
  assign two_x    = {one_x[AW-2:0], 1'b0};
  assign multiple = op_two ? two_x : one_x;
  assign addend   = op_en ? (op_sub ? ~multiple : multiple) : '0;
  assign psum     = acc_q + addend + AW'(op_en & op_sub);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      lo_q    <= '0;
      mcand_q <= '0;
      prev_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (hi_clr) begin
        acc_q   <= '0;
        mcand_q <= mcand;
        prev_q  <= 1'b0;
        busy_q  <= 1'b1;
        step_q  <= '0;
      end else if (hi_ld) begin
        acc_q  <= {{2{psum[AW-1]}}, psum[AW-1:2]};
        prev_q <= lo_q[1];
        step_q <= step_q + 1'b1;
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
      if (lo_ld)
        lo_q <= mplier;
      else if (shift_all)
        lo_q <= {psum[1:0], lo_q[WIDTH-1:2]};
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign hi   = acc_q[WIDTH-1:0];
  assign lo   = lo_q;

  p_reset_idle_r8: assert property (@(posedge clk) !rst_n |=> !busy_q && !done_q);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q && acc_q == '0 && lo_q == $past(mplier) && !prev_q);

  p_shift_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> lo_q[WIDTH-3:0] == $past(lo_q[WIDTH-1:2]));

  p_guard_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q[AW-1] == acc_q[AW-2]);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_busy_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q));

  p_operand_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(mcand_q));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(lo_q) && $stable(acc_q));
endmodule

// File: tb/booth_radix4_mul_bench.sv
module booth_radix4_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] mcand = '0;
  logic [31:0] mplier = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  booth_radix4_mul u_booth_radix4_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  function automatic logic [63:0] ref_product(logic [31:0] a, logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    return 64'(sa * sb);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic run_mul(logic [31:0] a, logic [31:0] b, bit disturb);
    logic [63:0] exp = ref_product(a, b);
    int n = 0;
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && hi === 32'd0 && lo === b, "R2",
          {31'd0, busy, lo}, {32'd1, b});
    while (done !== 1'b1 && n < 40) begin
      if (disturb && n == 5) begin
        start = 1'b1; mcand = $urandom; mplier = $urandom;
      end else if (disturb && n == 6) begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    check(n == 16, disturb ? "R5 timing" : "R3", 64'(n), 64'd16);
    check({hi, lo} === exp, disturb ? "R5 result" : "R1", {hi, lo}, exp);
    check(busy === 1'b0, "R3 busy low with done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    check(done === 1'b0, "R4 single pulse", {63'd0, done}, 64'd0);
    mcand = ~a; mplier = ~b;
    repeat (2) @(negedge clk);
    check({hi, lo} === exp, "R6 hold", {hi, lo}, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && hi === 32'd0 && lo === 32'd0, "R8",
          {hi, lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_mul(32'd0, 32'h1234_5678, 0);
    run_mul(32'd1, 32'd1, 0);
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_mul(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0);
    run_mul(32'h8000_0000, 32'h8000_0000, 0);
    run_mul(32'h8000_0000, 32'hFFFF_FFFF, 0);
    run_mul(32'h8000_0000, 32'h7FFF_FFFF, 0);
    run_mul(32'd3, 32'hFFFF_FFFB, 0);
    // R7: alternating patterns walk every recoding row
    run_mul(32'h0001_2345, 32'hAAAA_AAAA, 0);
    run_mul(32'hFEDC_BA98, 32'h5555_5555, 0);
    run_mul(32'h8765_4321, 32'h6DB6_DB6D, 0);
    run_mul(32'h0F0F_0F0F, 32'h3333_CCCC, 0);
    run_mul(32'hDEAD_BEEF, 32'h1357_9BDF, 1);
    for (int i = 0; i < 40; i++)
      run_mul($urandom, $urandom, (i % 7) == 3);
    finish_run();
  end
endmodule